// File: doc/BRIEF.md
# Serial Transmitter with Framing Options

This block is the transmit half of an asynchronous serial port. A host pushes 8-bit or 9-bit words through a one-cycle write strobe into a four-entry first-in-first-out queue. The block turns each queued word into a serial frame on a single output line. A frame is a low start bit, the data least significant bit first, an optional parity bit and one or two high stop bits. A bit clock comes from a 16-bit divisor followed by a selectable 16x or 4x oversampling count.

A clear-to-send input stops new frames from starting while it is low. A single-cycle request sends a break: the line is held low for a fixed long interval and then released. The block raises an interrupt level whenever the queue can take another word. It flags a write that was lost because the queue was full. The framing configuration is captured when each frame starts, so a change only affects later frames.

Top module: `sertx_top`

## Requirements
- R1: After reset the line output is high, busy is low, the queue-full flag is low and the interrupt is high.
- R2: A frame is a low start bit, then the data bits least significant first, then high stop bits. The line returns high and stays high between frames.
- R3: When `nine_bit_i` is 1, nine data bits are sent and no parity bit is inserted, whatever `parity_i` holds.
- R4: When `nine_bit_i` is 0, `parity_i` encodes 2'b00 as none, 2'b01 as even and 2'b10 as odd (2'b11 as none). Even parity is the XOR of the 8 data bits, and odd parity is its inverse. The parity bit follows the last data bit.
- R5: `two_stop_i` = 0 gives one stop bit and 1 gives two. When the queue stays non-empty, the next start bit begins exactly one clock after the last stop bit ends.
- R6: Every bit lasts exactly (`div_i`+1)×16 clocks with `os4_i` = 0, and (`div_i`+1)×4 clocks with `os4_i` = 1.
- R7: Words leave in the order they were written, and the queue holds 4 words.
- R8: A write while the queue holds 4 words is dropped. `wr_drop_o` is high for the cycle after such a write, and `full_o` is high while 4 words are held.
- R9: `irq_o` is high exactly when the queue has at least one free entry.
- R10: While `cts_i` is low, no new frame starts, and queued words wait.
- R11: A pulse on `brk_i` holds the line low for exactly 13 bit periods, then high for one bit period. A break takes precedence over queued words and is not gated by `cts_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | 16 | Bit-rate divisor |
| os4_i | input | 1 | 1 selects 4 clocks per divisor count, 0 selects 16 |
| nine_bit_i | input | 1 | 1 selects 9 data bits |
| parity_i | input | 2 | Parity select (none, even, odd) |
| two_stop_i | input | 1 | 1 selects two stop bits |
| cts_i | input | 1 | Clear to send, active high |
| wr_en_i | input | 1 | Write strobe for the queue |
| wr_data_i | input | 9 | Word to queue (bit 8 used only in 9-bit mode) |
| brk_i | input | 1 | Break request pulse |
| tx_o | output | 1 | Serial line, idle high |
| busy_o | output | 1 | A frame or break is in progress |
| full_o | output | 1 | Queue holds 4 words |
| wr_drop_o | output | 1 | A write was dropped on the previous cycle |
| irq_o | output | 1 | Queue has a free entry |

## Verification
The hardest condition to reach is a full queue with a write arriving on top of it. When the line is clear to send, the transmitter drains the queue almost as soon as it is written. The stimulus therefore drops `cts_i` first, writes five words, and checks the drop flag, the full flag and the interrupt. It also confirms that no start bit appears. It then releases `cts_i` and expects exactly the four accepted words, in order. Stop-bit count and bit period are checked by timing the gap between two back-to-back start bits, which must be one clock longer than the frame.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRK
  } tx_state_e;

  localparam logic [1:0] PAR_NONE = 2'b00;
  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;
endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int DIV_W   = 16,
  parameter int OS_SLOW = 16,
  parameter int OS_FAST = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             os4_i,
  output logic             tick_o
);
  localparam int OS_W = $clog2(OS_SLOW);

  logic [DIV_W-1:0] div_q;
  logic [OS_W-1:0]  os_q;
  logic [OS_W-1:0]  os_max;
  logic             div_wrap;

  assign os_max   = os4_i ? OS_W'(OS_FAST - 1) : OS_W'(OS_SLOW - 1);
  assign div_wrap = (div_q == div_i);
  assign tick_o   = run_i && div_wrap && (os_q == os_max);

  // counters sit at zero while idle so each frame starts phase-aligned
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      os_q  <= '0;
    end else if (!run_i) begin
      div_q <= '0;
      os_q  <= '0;
    end else if (div_wrap) begin
      div_q <= '0;
      os_q  <= (os_q == os_max) ? '0 : os_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // R6: bit period is at least 4 clocks, so ticks never come back to back
  p_tick_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int DW    = 9,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          drop_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          push, pull;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push    = wr_i && !full_o;
  assign pull    = pop_i && !empty_o;
  assign rdata_o = mem_q[rptr_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      drop_o <= 1'b0;
    end else begin
      drop_o <= wr_i && full_o;
      if (push) wptr_q <= nxt(wptr_q);
      if (pull) rptr_q <= nxt(rptr_q);
      case ({push, pull})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_drop_keeps_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_o && !pop_i) |=> $stable(cnt_q));
  p_drop_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_o) |=> drop_o);
  p_pop_nonempty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int DW       = 9,
  parameter int BRK_BITS = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          nine_bit_i,
  input  logic [1:0]    parity_i,
  input  logic          two_stop_i,
  input  logic          cts_i,
  input  logic          brk_i,
  input  logic          empty_i,
  input  logic [DW-1:0] data_i,
  output logic          pop_o,
  output logic          run_o,
  output logic          tx_o
);
  localparam int CNT_W = $clog2(BRK_BITS);

  tx_state_e       state_q;
  logic [DW-1:0]   sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic            nine_q, par_en_q, par_bit_q, stop2_q, stop_n_q, brk_pend_q;
  logic            take_brk, take_word;

  assign take_brk  = (state_q == ST_IDLE) && brk_pend_q;
  assign take_word = (state_q == ST_IDLE) && !brk_pend_q && !empty_i && cts_i;
  assign pop_o     = take_word;
  assign run_o     = (state_q != ST_IDLE);

  always_comb begin
    unique case (state_q)
      ST_START: tx_o = 1'b0;
      ST_DATA:  tx_o = sh_q[0];
      ST_PAR:   tx_o = par_bit_q;
      ST_BRK:   tx_o = 1'b0;
      default:  tx_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      sh_q       <= '0;
      cnt_q      <= '0;
      nine_q     <= 1'b0;
      par_en_q   <= 1'b0;
      par_bit_q  <= 1'b0;
      stop2_q    <= 1'b0;
      stop_n_q   <= 1'b0;
      brk_pend_q <= 1'b0;
    end else begin
      if (brk_i)         brk_pend_q <= 1'b1;
      else if (take_brk) brk_pend_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (take_brk) begin
            state_q <= ST_BRK;
            cnt_q   <= '0;
          end else if (take_word) begin
            // framing is captured per frame
            state_q   <= ST_START;
            sh_q      <= data_i;
            nine_q    <= nine_bit_i;
            stop2_q   <= two_stop_i;
            par_en_q  <= !nine_bit_i && (parity_i == PAR_EVEN || parity_i == PAR_ODD);
            par_bit_q <= (parity_i == PAR_ODD) ? ~^data_i[DW-2:0] : ^data_i[DW-2:0];
          end
        end
        ST_START: if (tick_i) begin
          state_q <= ST_DATA;
          cnt_q   <= '0;
        end
        ST_DATA: if (tick_i) begin
          sh_q <= sh_q >> 1;
          if (cnt_q == (nine_q ? CNT_W'(DW - 1) : CNT_W'(DW - 2))) begin
            state_q  <= par_en_q ? ST_PAR : ST_STOP;
            stop_n_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PAR: if (tick_i) begin
          state_q  <= ST_STOP;
          stop_n_q <= 1'b0;
        end
        ST_STOP: if (tick_i) begin
          if (stop2_q && !stop_n_q) stop_n_q <= 1'b1;
          else                      state_q  <= ST_IDLE;
        end
        ST_BRK: if (tick_i) begin
          if (cnt_q == CNT_W'(BRK_BITS - 1)) begin
            state_q  <= ST_STOP;
            stop2_q  <= 1'b0;
            stop_n_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_cts_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !cts_i && !brk_pend_q && !brk_i) |=> (state_q == ST_IDLE));
  p_break_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BRK) |-> !tx_o);
  p_start_after_pop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> (state_q == ST_START && !tx_o));
  p_no_parity_nine_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAR) |-> !nine_q);
endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
  parameter int DW       = 9,
  parameter int DEPTH    = 4,
  parameter int DIV_W    = 16,
  parameter int BRK_BITS = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             os4_i,
  input  logic             nine_bit_i,
  input  logic [1:0]       parity_i,
  input  logic             two_stop_i,
  input  logic             cts_i,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             brk_i,
  output logic             tx_o,
  output logic             busy_o,
  output logic             full_o,
  output logic             wr_drop_o,
  output logic             irq_o
);
  logic          tick, run, pop, empty;
  logic [DW-1:0] head;

  sertx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .wr_i(wr_en_i), .wdata_i(wr_data_i), .pop_i(pop),
    .rdata_o(head), .empty_o(empty), .full_o(full_o), .drop_o(wr_drop_o)
  );

  sertx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i, .rst_ni, .run_i(run), .div_i(div_i), .os4_i(os4_i), .tick_o(tick)
  );

  sertx_shifter #(.DW(DW), .BRK_BITS(BRK_BITS)) u_shift (
    .clk_i, .rst_ni, .tick_i(tick),
    .nine_bit_i, .parity_i, .two_stop_i, .cts_i, .brk_i,
    .empty_i(empty), .data_i(head),
    .pop_o(pop), .run_o(run), .tx_o(tx_o)
  );

  assign busy_o = run;
  assign irq_o  = !full_o;

  p_idle_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o);
  p_irq_free_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !wr_en_i) |=> irq_o);
endmodule

// File: tb/sertx_top_test.sv
module sertx_top_test;
  typedef struct {
    bit       brk;
    bit [8:0] data;
    bit       nine;
    bit [1:0] par;
    bit       stop2;
    int       per;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic [15:0] div = 0;
  logic os4 = 0, nine = 0, two_stop = 0, cts = 1, wr_en = 0, brk = 0;
  logic [1:0] par = 0;
  logic [8:0] wdata = 0;
  logic tx, busy, full, drop, irq;

  int n_tests = 0, n_fail = 0;
  longint cyc = 0;
  item_t sb[$];
  longint starts[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sertx_top uut (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .os4_i(os4), .nine_bit_i(nine),
    .parity_i(par), .two_stop_i(two_stop), .cts_i(cts), .wr_en_i(wr_en),
    .wr_data_i(wdata), .brk_i(brk), .tx_o(tx), .busy_o(busy), .full_o(full),
    .wr_drop_o(drop), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int per_now();
    return (int'(div) + 1) * (os4 ? 4 : 16);
  endfunction

  task automatic wr(input logic [8:0] d, input bit accept);
    item_t it;
    @(negedge clk);
    wr_en = 1; wdata = d;
    if (accept) begin
      it.brk = 0; it.data = d; it.nine = nine; it.par = par;
      it.stop2 = two_stop; it.per = per_now();
      sb.push_back(it);
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic send_break();
    item_t it;
    @(negedge clk);
    brk = 1;
    it.brk = 1; it.data = 0; it.nine = 0; it.par = 0; it.stop2 = 0; it.per = per_now();
    sb.push_back(it);
    @(negedge clk);
    brk = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy || sb.size() != 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic run_frame(input item_t it);
    int n;
    bit [8:0] got;
    bit pb, expb;
    int nb;
    if (it.brk) begin
      n = 1;
      @(negedge clk);
      while (!tx) begin n++; @(negedge clk); end
      chk(n == 13 * it.per, "R11 break low length", n, 13 * it.per);
      return;
    end
    repeat (it.per / 2 - 1) @(negedge clk);
    chk(!tx, "R2 start bit low", tx, 0);
    nb = it.nine ? 9 : 8;
    got = 0;
    for (int i = 0; i < nb; i++) begin
      repeat (it.per) @(negedge clk);
      got[i] = tx;
    end
    chk(got == (it.nine ? it.data : {1'b0, it.data[7:0]}),
        it.nine ? "R3 nine-bit data" : "R2 data lsb first",
        got, it.nine ? it.data : it.data[7:0]);
    if (!it.nine && (it.par == 2'b01 || it.par == 2'b10)) begin
      repeat (it.per) @(negedge clk);
      pb = tx;
      expb = (it.par == 2'b10) ? ~^it.data[7:0] : ^it.data[7:0];
      chk(pb == expb, "R4 parity bit", pb, expb);
    end
    for (int s = 0; s < (it.stop2 ? 2 : 1); s++) begin
      repeat (it.per) @(negedge clk);
      chk(tx, "R5 stop bit high", tx, 1);
    end
  endtask

  initial begin : monitor
    item_t it;
    bit prev;
    prev = 1;
    forever begin
      @(negedge clk);
      if (rst_n && prev && !tx) begin
        starts.push_back(cyc);
        if (sb.size() == 0) begin
          chk(0, "R10 unexpected frame start", 1, 0);
        end else begin
          it = sb.pop_front();
          run_frame(it);
        end
        prev = 1;
      end else begin
        prev = tx;
      end
    end
  end

  task automatic gap_chk(input int idx, input longint exp, input string req);
    if (starts.size() > idx + 1)
      chk(starts[idx+1] - starts[idx] == exp, req, starts[idx+1] - starts[idx], exp);
    else
      chk(0, req, starts.size(), idx + 2);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stim
    int base;
    repeat (3) @(negedge clk);
    chk(tx == 1 && busy == 0, "R1 reset line high idle", {tx, busy}, 2);
    chk(full == 0 && irq == 1, "R1 R9 reset queue flags", {full, irq}, 1);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // 8N1, 16x, div 1 -> 32 clocks per bit
    div = 1; os4 = 0; nine = 0; par = 2'b00; two_stop = 0;
    base = starts.size();
    wr(9'h0A5, 1); wr(9'h03C, 1);
    wait_idle();
    gap_chk(base, 10 * 32 + 1, "R6 R5 8N1 16x frame spacing");

    // 8E1, 4x, div 2 -> 12 clocks per bit
    div = 2; os4 = 1; par = 2'b01;
    base = starts.size();
    wr(9'h007, 1); wr(9'h055, 1);
    wait_idle();
    gap_chk(base, 11 * 12 + 1, "R6 R4 8E1 4x frame spacing");

    // 8O2
    par = 2'b10; two_stop = 1;
    base = starts.size();
    wr(9'h001, 1); wr(9'h0FE, 1);
    wait_idle();
    gap_chk(base, 12 * 12 + 1, "R5 two stop bits spacing");

    // 9-bit with parity requested: parity must be ignored
    nine = 1; par = 2'b01; two_stop = 0; div = 0; os4 = 1;
    base = starts.size();
    wr(9'h1A3, 1); wr(9'h0A3, 1);
    wait_idle();
    gap_chk(base, 11 * 4 + 1, "R3 nine-bit no parity spacing");

    // flow control and full queue
    nine = 0; par = 2'b00; div = 0; os4 = 1;
    @(negedge clk); cts = 0;
    base = starts.size();
    wr(9'h011, 1); wr(9'h022, 1); wr(9'h033, 1);
    chk(irq == 1 && full == 0, "R9 irq with free entry", irq, 1);
    wr(9'h044, 1);
    chk(full == 1, "R8 full after four writes", full, 1);
    chk(irq == 0, "R9 irq low when full", irq, 0);
    wr(9'h099, 0);
    chk(drop == 1, "R8 drop flag on full write", drop, 1);
    @(negedge clk);
    chk(drop == 0, "R8 drop flag single cycle", drop, 0);
    repeat (200) @(negedge clk);
    chk(starts.size() == base && tx == 1, "R10 no start while cts low", starts.size(), base);
    cts = 1;
    wait_idle();
    chk(starts.size() == base + 4, "R7 R8 four frames after release", starts.size(), base + 4);
    chk(irq == 1 && full == 0, "R9 irq back after drain", irq, 1);

    // break then a word
    div = 0; os4 = 1;
    base = starts.size();
    send_break();
    wr(9'h05A, 1);
    wait_idle();
    gap_chk(base, 14 * 4 + 1, "R11 break stop period");

    chk(sb.size() == 0, "R7 scoreboard drained", sb.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule